// File: doc/BRIEF.md
# Motor Drive Fault Latch Controller

This block collects every protection source of a motor inverter into one latched shutdown unit. External comparators and the gate driver report gate-kill (overcurrent or overtemperature), bus overvoltage, bus undervoltage, overspeed and phase loss. The block itself derives three more conditions:

- a computation overrun, from the carrier-period strobe and the control loop's done pulse;
- a zero-speed condition, from the measured speed and a programmed minimum speed;
- retry exhaustion, from a count of failed start attempts compared against a programmable limit.

Each source owns one sticky bit of an eight-bit fault flag vector. While any bit is set, the gate outputs are held at their idle level, the red lamp is lit and the green lamp is dark. The flags stay set after the cause disappears. They are released only by a level-sensitive clear, which comes either from a host control bit or from an external pin. The pin is synchronized first. While the clear level is held, the flags remain zero. When the clear is released with a cause still present, the flag returns on the next clock.

The zero-speed interval is counted in ticks from a prescaler. The prescaler is derived from the clock frequency parameter. By default the interval is 2000 ms.

Top module: `mdrv_fault_ctrl`

## Requirements
- R1: Flag bit positions are: 0 gate-kill, 1 overvoltage, 2 undervoltage, 3 overspeed, 4 overrun, 5 zero speed, 6 retry exhausted, 7 phase loss. A source that is active at a clock edge sets its bit after that edge, and the bit stays set after the source goes inactive, until a clear.
- R2: The gate outputs equal the PWM request only when no flag is set and none of the five external fault inputs is high. An external fault input forces the gates to idle in the same cycle, before any clock edge. A latched flag keeps them at idle. The idle level is 0 by default.
- R3: The red lamp is 1 and the green lamp is 0 while any flag is set. Otherwise the red lamp is 0 and the green lamp is 1.
- R4: While the host clear bit is high, all flags are zero after each edge, even when a source is active in the same cycle. If a source is still active when the clear drops, its flag is set again at the next edge.
- R5: The external clear pin passes through a SYNC_STAGES-flop synchronizer (2 by default), then acts like the host clear. Flags drop at the third edge after the pin rises.
- R6: Bit 5 is set when speed stays below floor(min_speed/2) for HOLD ticks without interruption. With the bench parameters (4 clocks per tick, 5 ticks), it sets at the 21st edge. Speed at or above the threshold restarts the interval.
- R7: Each cycle with the start-fail input high adds one to a saturating failure count. Bit 6 is set at the edge after the count reaches a nonzero retry limit. A limit of zero disables this fault. Any clear level zeroes the count.
- R8: A carrier strobe while the previous computation has not reported done sets bit 4. A done pulse in the same cycle as the strobe counts as finished in time.
- R9: After reset, all flags are zero, the green lamp is lit and the gates follow the PWM request.
- R10: Several sources active in one cycle set all of their bits together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_kill_i | input | 1 | Shutdown report from the external gate driver |
| bus_ov_i | input | 1 | DC bus overvoltage |
| bus_uv_i | input | 1 | DC bus undervoltage |
| overspeed_i | input | 1 | Motor speed above maximum |
| phase_loss_i | input | 1 | Loose motor phase connection |
| period_stb_i | input | 1 | Start of a PWM carrier period |
| calc_done_i | input | 1 | Control computation finished |
| speed_i | input | SPD_W | Measured speed |
| min_speed_i | input | SPD_W | Programmed minimum speed |
| start_fail_i | input | 1 | One failed start attempt per high cycle |
| retry_limit_i | input | RTY_W | Failure count that exhausts retries; 0 disables |
| host_clr_i | input | 1 | Host control clear bit (level) |
| clr_pin_i | input | 1 | External clear pin (level, asynchronous) |
| pwm_req_i | input | GATE_W | Gate pattern requested by the PWM generator |
| gate_o | output | GATE_W | Gate drive after protection |
| fault_flags_o | output | 8 | Sticky per-source fault flags |
| red_led_o | output | 1 | Fault lamp |
| green_led_o | output | 1 | Healthy lamp |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the clear level and a fresh fault: the bench raises the host clear bit and the gate-kill input in the same cycle. It expects zero flags with the gates at idle, and then the flag returning one edge after the clear drops. The second pair is the carrier strobe and the done pulse of the overrun monitor. The bench drives both in one cycle and expects no overrun, then drives a strobe alone and expects bit 4. A scoreboard compares the flags, gates and lamps against values derived from the requirements.

// File: rtl/mdrv_fault_pkg.sv
package mdrv_fault_pkg;
   localparam int NUM_FLT   = 8;
   localparam int FLT_GKILL = 0;
   localparam int FLT_OVOLT = 1;
   localparam int FLT_UVOLT = 2;
   localparam int FLT_OSPD  = 3;
   localparam int FLT_OVRUN = 4;
   localparam int FLT_ZSPD  = 5;
   localparam int FLT_RETRY = 6;
   localparam int FLT_PLOSS = 7;
   typedef logic [NUM_FLT-1:0] flt_vec_t;
endpackage

// File: rtl/mdrv_clr_sync.sv
module mdrv_clr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic lvl_o
);
   if (STAGES == 0) begin : g_bypass
      assign lvl_o = pin_i;
   end else begin : g_chain
      logic [STAGES-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_q <= '0;
         end else begin
            stg_q[0] <= pin_i;
            for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
         end
      end
      assign lvl_o = stg_q[STAGES-1];
   end
endmodule

// File: rtl/mdrv_zero_speed_timer.sv
module mdrv_zero_speed_timer #(
   parameter int SPD_W      = 12,
   parameter int DIV        = 100000,
   parameter int HOLD_TICKS = 2000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SPD_W-1:0] speed_i,
   input  logic [SPD_W-1:0] min_speed_i,
   output logic             zs_o
);
   localparam int DIV_W  = (DIV > 1) ? $clog2(DIV) : 1;
   localparam int HOLD_W = $clog2(HOLD_TICKS + 1);

   logic              below;
   logic [DIV_W-1:0]  pre_q;
   logic [HOLD_W-1:0] cnt_q;

   assign below = speed_i < (min_speed_i >> 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else if (!below) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else if (pre_q == DIV_W'(DIV - 1)) begin
         pre_q <= '0;
         if (cnt_q != HOLD_W'(HOLD_TICKS)) cnt_q <= cnt_q + HOLD_W'(1);
      end else begin
         pre_q <= pre_q + DIV_W'(1);
      end
   end

   assign zs_o = (cnt_q == HOLD_W'(HOLD_TICKS));
endmodule

// File: rtl/mdrv_retry_counter.sv
module mdrv_retry_counter #(
   parameter int RTY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             fail_i,
   input  logic [RTY_W-1:0] limit_i,
   output logic             exh_o
);
   logic [RTY_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (fail_i && (cnt_q != '1)) begin
         cnt_q <= cnt_q + RTY_W'(1);
      end
   end

   assign exh_o = (limit_i != '0) && (cnt_q >= limit_i);
endmodule

// File: rtl/mdrv_overrun_mon.sv
module mdrv_overrun_mon (
   input  logic clk,
   input  logic rst_n,
   input  logic period_stb_i,
   input  logic calc_done_i,
   output logic ovr_o
);
   logic busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
      end else if (period_stb_i) begin
         busy_q <= 1'b1;
      end else if (calc_done_i) begin
         busy_q <= 1'b0;
      end
   end

   assign ovr_o = period_stb_i & busy_q & ~calc_done_i;
endmodule

// File: rtl/mdrv_fault_ctrl.sv
module mdrv_fault_ctrl
   import mdrv_fault_pkg::*;
#(
   parameter int   CLK_HZ        = 100000000,
   parameter int   TICK_HZ       = 1000,
   parameter int   HOLD_MS       = 2000,
   parameter int   SPD_W         = 12,
   parameter int   RTY_W         = 4,
   parameter int   GATE_W        = 6,
   parameter int   SYNC_STAGES   = 2,
   parameter bit   GATE_IDLE_LVL = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               gate_kill_i,
   input  logic               bus_ov_i,
   input  logic               bus_uv_i,
   input  logic               overspeed_i,
   input  logic               phase_loss_i,
   input  logic               period_stb_i,
   input  logic               calc_done_i,
   input  logic [SPD_W-1:0]   speed_i,
   input  logic [SPD_W-1:0]   min_speed_i,
   input  logic               start_fail_i,
   input  logic [RTY_W-1:0]   retry_limit_i,
   input  logic               host_clr_i,
   input  logic               clr_pin_i,
   input  logic [GATE_W-1:0]  pwm_req_i,
   output logic [GATE_W-1:0]  gate_o,
   output logic [NUM_FLT-1:0] fault_flags_o,
   output logic               red_led_o,
   output logic               green_led_o
);
   localparam int TICK_DIV   = CLK_HZ / TICK_HZ;
   localparam int HOLD_TICKS = (HOLD_MS * TICK_HZ) / 1000;

   if (TICK_HZ < 1 || CLK_HZ < TICK_HZ) begin : g_bad_clk
      $error("mdrv_fault_ctrl: CLK_HZ must be at least TICK_HZ and TICK_HZ positive");
   end
   if (HOLD_TICKS < 1) begin : g_bad_hold
      $error("mdrv_fault_ctrl: HOLD_MS shorter than one tick");
   end
   if (SPD_W < 2 || RTY_W < 1 || GATE_W < 1) begin : g_bad_width
      $error("mdrv_fault_ctrl: width parameter out of range");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("mdrv_fault_ctrl: SYNC_STAGES must be 0..4");
   end

   logic     pin_lvl, clr_lvl;
   logic     zs_flt, retry_flt, ovr_flt;
   logic     ext_any;
   flt_vec_t src;
   flt_vec_t flags_q;

   mdrv_clr_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (clr_pin_i),
      .lvl_o (pin_lvl)
   );

   assign clr_lvl = host_clr_i | pin_lvl;

   mdrv_zero_speed_timer #(
      .SPD_W      (SPD_W),
      .DIV        (TICK_DIV),
      .HOLD_TICKS (HOLD_TICKS)
   ) u_zspd (
      .clk         (clk),
      .rst_n       (rst_n),
      .speed_i     (speed_i),
      .min_speed_i (min_speed_i),
      .zs_o        (zs_flt)
   );

   mdrv_retry_counter #(.RTY_W(RTY_W)) u_retry (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr_lvl),
      .fail_i  (start_fail_i),
      .limit_i (retry_limit_i),
      .exh_o   (retry_flt)
   );

   mdrv_overrun_mon u_ovrun (
      .clk          (clk),
      .rst_n        (rst_n),
      .period_stb_i (period_stb_i),
      .calc_done_i  (calc_done_i),
      .ovr_o        (ovr_flt)
   );

   always_comb begin
      src            = '0;
      src[FLT_GKILL] = gate_kill_i;
      src[FLT_OVOLT] = bus_ov_i;
      src[FLT_UVOLT] = bus_uv_i;
      src[FLT_OSPD]  = overspeed_i;
      src[FLT_OVRUN] = ovr_flt;
      src[FLT_ZSPD]  = zs_flt;
      src[FLT_RETRY] = retry_flt;
      src[FLT_PLOSS] = phase_loss_i;
   end

   assign ext_any = gate_kill_i | bus_ov_i | bus_uv_i | overspeed_i | phase_loss_i;

   for (genvar i = 0; i < NUM_FLT; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags_q[i] <= 1'b0;
         end else if (clr_lvl) begin
            flags_q[i] <= 1'b0;
         end else if (src[i]) begin
            flags_q[i] <= 1'b1;
         end
      end
   end

   logic gate_block;
   assign gate_block = (|flags_q) | ext_any;

   if (GATE_IDLE_LVL) begin : g_idle_high
      assign gate_o = gate_block ? '1 : pwm_req_i;
   end else begin : g_idle_low
      assign gate_o = gate_block ? '0 : pwm_req_i;
   end

   assign fault_flags_o = flags_q;
   assign red_led_o     = |flags_q;
   assign green_led_o   = ~(|flags_q);
endmodule

// File: rtl/mdrv_fault_ctrl_chk.sv
module mdrv_fault_ctrl_chk #(
   parameter int GATE_W        = 6,
   parameter int RTY_W         = 4,
   parameter bit GATE_IDLE_LVL = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [7:0]        flags,
   input logic [GATE_W-1:0] gate,
   input logic [GATE_W-1:0] pwm_req,
   input logic              ext_any,
   input logic              host_clr,
   input logic              clr_lvl,
   input logic              red,
   input logic              green,
   input logic [RTY_W-1:0]  retry_limit,
   input logic              period_stb,
   input logic              calc_done
);
   assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_lvl |=> ((flags & $past(flags)) == $past(flags)));

   assert_gate_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((|flags) || ext_any) |-> (gate == {GATE_W{GATE_IDLE_LVL}}));

   assert_gate_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|flags) && !ext_any) |-> (gate == pwm_req));

   assert_led_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
      red != green);

   assert_red_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(red) |-> !$past(clr_lvl));

   assert_host_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      host_clr |=> (flags == 8'h00));

   assert_retry_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[6]) |-> ($past(retry_limit) != '0));

   assert_ovr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[4]) |-> $past(period_stb && !calc_done));
endmodule

bind mdrv_fault_ctrl mdrv_fault_ctrl_chk #(
   .GATE_W        (GATE_W),
   .RTY_W         (RTY_W),
   .GATE_IDLE_LVL (GATE_IDLE_LVL)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flags       (fault_flags_o),
   .gate        (gate_o),
   .pwm_req     (pwm_req_i),
   .ext_any     (ext_any),
   .host_clr    (host_clr_i),
   .clr_lvl     (clr_lvl),
   .red         (red_led_o),
   .green       (green_led_o),
   .retry_limit (retry_limit_i),
   .period_stb  (period_stb_i),
   .calc_done   (calc_done_i)
);

// File: tb/test_mdrv_fault_ctrl.sv
module test_mdrv_fault_ctrl;
   localparam int GW = 6;
   localparam int SW = 12;
   localparam int RW = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n;
   logic          gate_kill, bus_ov, bus_uv, ospd, ploss;
   logic          period_stb, calc_done, start_fail;
   logic [SW-1:0] speed, min_speed;
   logic [RW-1:0] retry_limit;
   logic          host_clr, clr_pin;
   logic [GW-1:0] pwm_req, gate;
   logic [7:0]    flags;
   logic          red, green;

   mdrv_fault_ctrl #(
      .CLK_HZ(4000), .TICK_HZ(1000), .HOLD_MS(5),
      .SPD_W(SW), .RTY_W(RW), .GATE_W(GW), .SYNC_STAGES(2), .GATE_IDLE_LVL(1'b0)
   ) i_mdrv_fault_ctrl (
      .clk(clk), .rst_n(rst_n),
      .gate_kill_i(gate_kill), .bus_ov_i(bus_ov), .bus_uv_i(bus_uv),
      .overspeed_i(ospd), .phase_loss_i(ploss),
      .period_stb_i(period_stb), .calc_done_i(calc_done),
      .speed_i(speed), .min_speed_i(min_speed),
      .start_fail_i(start_fail), .retry_limit_i(retry_limit),
      .host_clr_i(host_clr), .clr_pin_i(clr_pin),
      .pwm_req_i(pwm_req), .gate_o(gate),
      .fault_flags_o(flags), .red_led_o(red), .green_led_o(green)
   );

   typedef struct {
      string         req;
      logic [7:0]    flags;
      logic [GW-1:0] gate;
      logic          red;
      logic          green;
   } exp_t;

   exp_t sbq[$];
   int   total = 0;
   int   bad   = 0;

   // driver side: expected values derived from the requirements
   task automatic push_exp(input string req, input logic [7:0] f);
      exp_t e;
      logic ext;
      ext     = gate_kill | bus_ov | bus_uv | ospd | ploss;
      e.req   = req;
      e.flags = f;
      e.gate  = ((f != 8'h00) || ext) ? '0 : pwm_req;
      e.red   = (f != 8'h00);
      e.green = (f == 8'h00);
      sbq.push_back(e);
   endtask

   task automatic step(input int n);
      repeat (n) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic chk_step(input string req, input logic [7:0] f);
      push_exp(req, f);
      step(1);
   endtask

   task automatic check_now(input string req, input logic [GW-1:0] exp_gate);
      total++;
      if (gate !== exp_gate) begin
         bad++;
         $display("FAIL %s gate=%b expected=%b", req, gate, exp_gate);
      end
   endtask

   task automatic host_clear();
      host_clr = 1'b1;
      chk_step("R4 clear held", 8'h00);
      host_clr = 1'b0;
      chk_step("R4 clear released", 8'h00);
   endtask

   task automatic set_ext(input int idx, input logic v);
      case (idx)
         0: gate_kill = v;
         1: bus_ov    = v;
         2: bus_uv    = v;
         3: ospd      = v;
         default: ploss = v;
      endcase
   endtask

   // monitor: pops one expected item per falling edge
   always @(negedge clk) begin : mon
      exp_t e;
      if (sbq.size() > 0) begin
         e = sbq.pop_front();
         total++;
         if (flags !== e.flags || gate !== e.gate || red !== e.red || green !== e.green) begin
            bad++;
            $display("FAIL %s flags=%h gate=%b red=%b green=%b expected flags=%h gate=%b red=%b green=%b",
                     e.req, flags, gate, red, green, e.flags, e.gate, e.red, e.green);
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      int ids[5];
      ids = '{0, 1, 2, 3, 7};
      rst_n = 1'b0;
      gate_kill = 0; bus_ov = 0; bus_uv = 0; ospd = 0; ploss = 0;
      period_stb = 0; calc_done = 0; start_fail = 0;
      speed = 12'd500; min_speed = 12'd100; retry_limit = 4'd3;
      host_clr = 0; clr_pin = 0; pwm_req = 6'b101010;
      step(3);
      rst_n = 1'b1;
      chk_step("R9 reset state", 8'h00);

      // R1 / R2 / R3 per external source
      for (int k = 0; k < 5; k++) begin
         set_ext(ids[k], 1'b1);
         #1;
         check_now("R2 immediate gate idle", '0);
         chk_step("R1 source sets its bit", 8'(1 << ids[k]));
         set_ext(ids[k], 1'b0);
         chk_step("R1 bit sticky after source drops", 8'(1 << ids[k]));
         chk_step("R3 lamps while latched", 8'(1 << ids[k]));
         host_clear();
      end

      // R4 clear while cause persists
      bus_uv = 1'b1;
      chk_step("R4 undervoltage latched", 8'h04);
      host_clr = 1'b1;
      chk_step("R4 flags held zero under clear", 8'h00);
      chk_step("R4 flags held zero under clear", 8'h00);
      host_clr = 1'b0;
      chk_step("R4 refault on release", 8'h04);
      bus_uv = 1'b0;
      host_clear();

      // R4 clear and new fault in the same cycle
      host_clr = 1'b1;
      gate_kill = 1'b1;
      chk_step("R4 clear beats same-cycle fault", 8'h00);
      host_clr = 1'b0;
      chk_step("R4 fault returns after clear", 8'h01);
      gate_kill = 1'b0;
      host_clear();

      // R5 external clear pin through synchronizer
      ospd = 1'b1;
      step(1);
      ospd = 1'b0;
      clr_pin = 1'b1;
      chk_step("R5 pin edge 1 no effect", 8'h08);
      chk_step("R5 pin edge 2 no effect", 8'h08);
      chk_step("R5 pin edge 3 clears", 8'h00);
      clr_pin = 1'b0;
      step(3);
      chk_step("R5 stays clear after pin release", 8'h00);

      // R8 overrun monitor
      period_stb = 1'b1;
      chk_step("R8 first strobe", 8'h00);
      period_stb = 1'b0; calc_done = 1'b1;
      chk_step("R8 done in time", 8'h00);
      period_stb = 1'b1; calc_done = 1'b0;
      chk_step("R8 strobe after done", 8'h00);
      calc_done = 1'b1;
      chk_step("R8 done with strobe same cycle", 8'h00);
      calc_done = 1'b0;
      chk_step("R8 strobe while busy", 8'h10);
      period_stb = 1'b0; calc_done = 1'b1;
      step(1);
      calc_done = 1'b0;
      host_clear();

      // R7 retry exhaustion, limit 3
      start_fail = 1'b1;
      chk_step("R7 first failure", 8'h00);
      start_fail = 1'b0;
      step(1);
      start_fail = 1'b1;
      chk_step("R7 second failure", 8'h00);
      chk_step("R7 third failure counted", 8'h00);
      start_fail = 1'b0;
      chk_step("R7 limit reached", 8'h40);
      host_clear();
      chk_step("R7 count cleared by clear", 8'h00);
      retry_limit = 4'd0;
      start_fail = 1'b1;
      step(5);
      start_fail = 1'b0;
      chk_step("R7 limit zero disables", 8'h00);

      // R6 zero speed, threshold 50
      speed = 12'd50;
      step(39);
      chk_step("R6 speed at threshold", 8'h00);
      speed = 12'd49;
      step(19);
      chk_step("R6 one edge before hold", 8'h00);
      chk_step("R6 hold elapsed", 8'h20);
      speed = 12'd500;
      host_clear();
      speed = 12'd10;
      step(12);
      speed = 12'd60;
      step(1);
      speed = 12'd10;
      step(19);
      chk_step("R6 interval restarted", 8'h00);
      chk_step("R6 full interval after restart", 8'h20);
      speed = 12'd500;
      host_clear();

      // R10 simultaneous sources
      ploss = 1'b1; bus_ov = 1'b1;
      chk_step("R10 two sources together", 8'h82);
      ploss = 1'b0; bus_ov = 1'b0;
      chk_step("R10 both bits sticky", 8'h82);
      host_clear();
      pwm_req = 6'b010101;
      chk_step("R2 pass-through new pattern", 8'h00);

      step(2);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule